// File: doc/BRIEF.md
# Pipelined Floating-Point Adder/Subtractor

This block adds or subtracts two floating-point operands in four register-separated segments. Each operand has a sign bit, an unsigned exponent and a fraction mantissa. A nonzero operand is normalized, so its value is 0.1xxx (binary) times two to the power of the exponent. The first segment compares the exponents by subtraction. The second shifts the mantissa with the smaller exponent into alignment. The third adds or subtracts the magnitudes. The fourth normalizes the result.

A new operation may be presented on every clock under `in_valid`. The normalized result appears four cycles later under `out_valid`. Bits shifted out during alignment or normalization are dropped, so the result is truncated and never rounded. Exponent overflow saturates. Exponent underflow flushes the result to zero.

Top module: `fpadd_pipe`

## Requirements
- R1: An operand with mantissa zero is zero, whatever its exponent field holds. Otherwise its value is mantissa/2^MW times 2^exponent, with the mantissa MSB set. `op_sub`=1 computes X−Y and `op_sub`=0 computes X+Y. A sign bit of 1 means negative.
- R2: `out_valid` equals `in_valid` from exactly four clocks earlier. One operation is accepted per clock, idle cycles pass through as idle cycles, and results leave in issue order.
- R3: The operand with the smaller exponent is shifted right by the exponent difference, and the bits shifted out are lost. When the difference is MW or more, that operand contributes zero. When the exponents are equal, Y is the operand shifted, by zero.
- R4: Before normalization, the result exponent is the larger exponent. The result sign is the sign of the signed sum of the two aligned terms.
- R5: If the magnitude sum carries past the binary point, the mantissa shifts right by one and the exponent rises by one.
- R6: If the magnitude has leading zeros after a subtraction, it shifts left until its MSB is 1, and the exponent drops by the shift count.
- R7: A zero magnitude gives the canonical zero: sign 0, exponent 0, mantissa 0.
- R8: If normalization would need an exponent below zero, the result is the canonical zero.
- R9: A carry while the exponent is already at its maximum saturates the result. The exponent stays at its maximum, the mantissa is all ones, and the sign is kept.
- R10: While reset is high, and on the first clock after it, `out_valid` is 0 and the result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and operation are valid this cycle |
| x_sign | input | 1 | Sign of X |
| x_exp | input | EW | Exponent of X |
| x_man | input | MW | Fraction mantissa of X |
| y_sign | input | 1 | Sign of Y |
| y_exp | input | EW | Exponent of Y |
| y_man | input | MW | Fraction mantissa of Y |
| op_sub | input | 1 | 1: X−Y, 0: X+Y |
| out_valid | output | 1 | Result valid |
| z_sign | output | 1 | Result sign |
| z_exp | output | EW | Result exponent |
| z_man | output | MW | Result mantissa, normalized or zero |

## Verification
The bench builds the block with a 4-bit exponent and a 6-bit mantissa. In that configuration every pair of normalized-or-zero mantissas can be swept under every sign and operation combination. Eight chosen exponent pairs then bring each case within reach:
- equal exponents, where full cancellation and sign flips occur;
- small differences that truncate bits;
- a difference exactly equal to the mantissa width, and one beyond it, where the smaller operand vanishes;
- the maximum exponent, where saturation occurs;
- tiny exponents, where the left shift underflows to zero.

Operations stream back to back with periodic idle gaps, so ordering and latency are checked under full throughput.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  localparam int DEF_EW = 8;
  localparam int DEF_MW = 16;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } fadd_op_e;
endpackage

// File: rtl/fpadd_cmp.sv
module fpadd_cmp
  import fpadd_pkg::*;
#(
  parameter int EW = DEF_EW,
  parameter int MW = DEF_MW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          x_s,
  input  logic [EW-1:0] x_e,
  input  logic [MW-1:0] x_m,
  input  logic          y_s,
  input  logic [EW-1:0] y_e,
  input  logic [MW-1:0] y_m,
  input  fadd_op_e      op,
  output logic          out_valid,
  output logic [EW-1:0] exp_q,
  output logic [EW-1:0] shamt_q,
  output logic [MW-1:0] big_m_q,
  output logic [MW-1:0] small_m_q,
  output logic          big_s_q,
  output logic          small_s_q
);
  logic [EW-1:0] xe_eff, ye_eff;
  logic [EW:0]   diff, ndiff;
  logic          swap, ys_eff;

  always_comb begin
    xe_eff = (x_m == '0) ? '0 : x_e;
    ye_eff = (y_m == '0) ? '0 : y_e;
    diff   = {1'b0, xe_eff} - {1'b0, ye_eff};
    ndiff  = '0 - diff;
    swap   = diff[EW];
    ys_eff = y_s ^ (op == OP_SUB);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      exp_q     <= '0;
      shamt_q   <= '0;
      big_m_q   <= '0;
      small_m_q <= '0;
      big_s_q   <= 1'b0;
      small_s_q <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (swap) begin
        exp_q     <= ye_eff;
        shamt_q   <= ndiff[EW-1:0];
        big_m_q   <= y_m;
        small_m_q <= x_m;
        big_s_q   <= ys_eff;
        small_s_q <= x_s;
      end else begin
        exp_q     <= xe_eff;
        shamt_q   <= diff[EW-1:0];
        big_m_q   <= x_m;
        small_m_q <= y_m;
        big_s_q   <= x_s;
        small_s_q <= ys_eff;
      end
    end
  end

  // R4
  larger_exp_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (exp_q >= $past(xe_eff)) && (exp_q >= $past(ye_eff)));
endmodule

// File: rtl/fpadd_align.sv
module fpadd_align
  import fpadd_pkg::*;
#(
  parameter int EW = DEF_EW,
  parameter int MW = DEF_MW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [EW-1:0] exp_i,
  input  logic [EW-1:0] shamt_i,
  input  logic [MW-1:0] big_m_i,
  input  logic [MW-1:0] small_m_i,
  input  logic          big_s_i,
  input  logic          small_s_i,
  output logic          out_valid,
  output logic [EW-1:0] exp_q,
  output logic [MW-1:0] big_m_q,
  output logic [MW-1:0] small_m_q,
  output logic          big_s_q,
  output logic          small_s_q
);
  logic          gone;
  logic [MW-1:0] shifted;

  always_comb begin
    gone    = int'(shamt_i) >= MW;
    shifted = gone ? '0 : (small_m_i >> shamt_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      exp_q     <= '0;
      big_m_q   <= '0;
      small_m_q <= '0;
      big_s_q   <= 1'b0;
      small_s_q <= 1'b0;
    end else begin
      out_valid <= in_valid;
      exp_q     <= exp_i;
      big_m_q   <= big_m_i;
      small_m_q <= shifted;
      big_s_q   <= big_s_i;
      small_s_q <= small_s_i;
    end
  end

  // R3
  far_operand_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && int'(shamt_i) >= MW) |=> (small_m_q == '0));

  // R3
  zero_shift_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && shamt_i == '0) |=> (small_m_q == $past(small_m_i)));
endmodule

// File: rtl/fpadd_addsub.sv
module fpadd_addsub
  import fpadd_pkg::*;
#(
  parameter int EW = DEF_EW,
  parameter int MW = DEF_MW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [EW-1:0] exp_i,
  input  logic [MW-1:0] big_m_i,
  input  logic [MW-1:0] small_m_i,
  input  logic          big_s_i,
  input  logic          small_s_i,
  output logic          out_valid,
  output logic [EW-1:0] exp_q,
  output logic          sign_q,
  output logic [MW:0]   mag_q
);
  logic [MW:0] mag_n;
  logic        sign_n;

  always_comb begin
    if (big_s_i == small_s_i) begin
      mag_n  = {1'b0, big_m_i} + {1'b0, small_m_i};
      sign_n = big_s_i;
    end else if (big_m_i >= small_m_i) begin
      mag_n  = {1'b0, big_m_i} - {1'b0, small_m_i};
      sign_n = big_s_i;
    end else begin
      mag_n  = {1'b0, small_m_i} - {1'b0, big_m_i};
      sign_n = small_s_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      exp_q     <= '0;
      sign_q    <= 1'b0;
      mag_q     <= '0;
    end else begin
      out_valid <= in_valid;
      exp_q     <= exp_i;
      sign_q    <= sign_n;
      mag_q     <= mag_n;
    end
  end

  // R4
  add_grows_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && big_s_i == small_s_i) |=> (mag_q >= {1'b0, $past(big_m_i)}));
endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm
  import fpadd_pkg::*;
#(
  parameter int EW = DEF_EW,
  parameter int MW = DEF_MW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [EW-1:0] exp_i,
  input  logic          sign_i,
  input  logic [MW:0]   mag_i,
  output logic          out_valid,
  output logic          z_s,
  output logic [EW-1:0] z_e,
  output logic [MW-1:0] z_m
);
  localparam int CW = $clog2(MW + 1);
  localparam logic [EW-1:0] EMAX = '1;

  function automatic logic [CW-1:0] lead_zeros(input logic [MW-1:0] v);
    logic [CW-1:0] n;
    n = CW'(MW);
    for (int i = 0; i < MW; i++) begin
      if (v[i]) n = CW'(MW - 1 - i);
    end
    return n;
  endfunction

  logic [CW-1:0] lz;
  logic          nz_s;
  logic [EW-1:0] nz_e;
  logic [MW-1:0] nz_m;

  always_comb begin
    lz   = lead_zeros(mag_i[MW-1:0]);
    nz_s = sign_i;
    nz_e = exp_i;
    nz_m = mag_i[MW-1:0];
    if (mag_i[MW]) begin
      if (exp_i == EMAX) begin
        nz_e = EMAX;
        nz_m = '1;
      end else begin
        nz_e = exp_i + 1'b1;
        nz_m = mag_i[MW:1];
      end
    end else if (mag_i == '0 || int'(lz) > int'(exp_i)) begin
      nz_s = 1'b0;
      nz_e = '0;
      nz_m = '0;
    end else begin
      nz_m = mag_i[MW-1:0] << lz;
      nz_e = exp_i - EW'(lz);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      z_s       <= 1'b0;
      z_e       <= '0;
      z_m       <= '0;
    end else begin
      out_valid <= in_valid;
      z_s       <= nz_s;
      z_e       <= nz_e;
      z_m       <= nz_m;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R6
  normalized_out_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && z_m != '0) |-> z_m[MW-1]);

  // R7
  canonical_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && z_m == '0) |-> (z_e == '0 && !z_s));

  // R5
  carry_bump_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mag_i[MW] && exp_i != EMAX) |=> (z_e == $past(exp_i) + 1'b1));
endmodule

// File: rtl/fpadd_pipe.sv
module fpadd_pipe
  import fpadd_pkg::*;
#(
  parameter int EW = DEF_EW,
  parameter int MW = DEF_MW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          x_sign,
  input  logic [EW-1:0] x_exp,
  input  logic [MW-1:0] x_man,
  input  logic          y_sign,
  input  logic [EW-1:0] y_exp,
  input  logic [MW-1:0] y_man,
  input  logic          op_sub,
  output logic          out_valid,
  output logic          z_sign,
  output logic [EW-1:0] z_exp,
  output logic [MW-1:0] z_man
);
  fadd_op_e op;
  assign op = op_sub ? OP_SUB : OP_ADD;

  logic          v1, bs1, ss1;
  logic [EW-1:0] e1, sh1;
  logic [MW-1:0] bm1, sm1;

  logic          v2, bs2, ss2;
  logic [EW-1:0] e2;
  logic [MW-1:0] bm2, sm2;

  logic          v3, s3;
  logic [EW-1:0] e3;
  logic [MW:0]   m3;

  fpadd_cmp #(.EW(EW), .MW(MW)) u_cmp (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .x_s(x_sign), .x_e(x_exp), .x_m(x_man),
    .y_s(y_sign), .y_e(y_exp), .y_m(y_man), .op(op),
    .out_valid(v1), .exp_q(e1), .shamt_q(sh1),
    .big_m_q(bm1), .small_m_q(sm1), .big_s_q(bs1), .small_s_q(ss1)
  );

  fpadd_align #(.EW(EW), .MW(MW)) u_align (
    .clk(clk), .rst(rst), .in_valid(v1),
    .exp_i(e1), .shamt_i(sh1), .big_m_i(bm1), .small_m_i(sm1),
    .big_s_i(bs1), .small_s_i(ss1),
    .out_valid(v2), .exp_q(e2), .big_m_q(bm2), .small_m_q(sm2),
    .big_s_q(bs2), .small_s_q(ss2)
  );

  fpadd_addsub #(.EW(EW), .MW(MW)) u_addsub (
    .clk(clk), .rst(rst), .in_valid(v2),
    .exp_i(e2), .big_m_i(bm2), .small_m_i(sm2),
    .big_s_i(bs2), .small_s_i(ss2),
    .out_valid(v3), .exp_q(e3), .sign_q(s3), .mag_q(m3)
  );

  fpadd_norm #(.EW(EW), .MW(MW)) u_norm (
    .clk(clk), .rst(rst), .in_valid(v3),
    .exp_i(e3), .sign_i(s3), .mag_i(m3),
    .out_valid(out_valid), .z_s(z_sign), .z_e(z_exp), .z_m(z_man)
  );
endmodule

// File: tb/fpadd_pipe_bench.sv
`timescale 1ns/1ps
module fpadd_pipe_bench;
  localparam int EW   = 4;
  localparam int MW   = 6;
  localparam int EMAX = (1 << EW) - 1;
  localparam int NM   = 1 << (MW - 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          x_sign = 1'b0, y_sign = 1'b0, op_sub = 1'b0;
  logic [EW-1:0] x_exp = '0, y_exp = '0;
  logic [MW-1:0] x_man = '0, y_man = '0;
  logic          out_valid, z_sign;
  logic [EW-1:0] z_exp;
  logic [MW-1:0] z_man;

  always #2 clk = ~clk;

  fpadd_pipe #(.EW(EW), .MW(MW)) u_fpadd_pipe (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .x_sign(x_sign), .x_exp(x_exp), .x_man(x_man),
    .y_sign(y_sign), .y_exp(y_exp), .y_man(y_man), .op_sub(op_sub),
    .out_valid(out_valid), .z_sign(z_sign), .z_exp(z_exp), .z_man(z_man)
  );

  int checks = 0;
  int fails  = 0;
  int q_s [32];
  int q_e [32];
  int q_m [32];
  int q_t [32];
  int wptr = 0, rptr = 0;
  logic [3:0] hist = '0;

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
  endtask

  function automatic string tag_name(input int t);
    case (t)
      3: return "R3";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      9: return "R9";
      default: return "R4";
    endcase
  endfunction

  // Arithmetic model of the requirements (R1, R3-R9).
  task automatic model(input int xs, xe, xm, ys, ye, ym, op,
                       output int rs, re, rm, rt);
    int ex, ey, sy, e, d, vx, vy, s, m, sh;
    rt = 4;
    ex = (xm == 0) ? 0 : xe;
    ey = (ym == 0) ? 0 : ye;
    sy = ys ^ op;
    if (ex >= ey) begin
      e = ex; d = ex - ey;
      vx = xs ? -xm : xm;
      vy = (d >= MW) ? 0 : (ym >> d);
      if (sy) vy = -vy;
      if (d >= MW && ym != 0) rt = 3;
    end else begin
      e = ey; d = ey - ex;
      vy = sy ? -ym : ym;
      vx = (d >= MW) ? 0 : (xm >> d);
      if (xs) vx = -vx;
      if (d >= MW && xm != 0) rt = 3;
    end
    s  = vx + vy;
    rs = (s < 0) ? 1 : 0;
    m  = (s < 0) ? -s : s;
    if (m == 0) begin
      rs = 0; re = 0; rm = 0; rt = 7;
    end else if (m >= (1 << MW)) begin
      m = m >> 1; e = e + 1; rt = 5;
      if (e > EMAX) begin
        e = EMAX; m = (1 << MW) - 1; rt = 9;
      end
      re = e; rm = m;
    end else begin
      sh = 0;
      while (m < NM) begin
        m = m << 1; e = e - 1; sh++;
      end
      if (sh > 0) rt = 6;
      if (e < 0) begin
        rs = 0; re = 0; rm = 0; rt = 8;
      end else begin
        re = e; rm = m;
      end
    end
  endtask

  task automatic check_out();
    checks++;
    if (out_valid !== hist[3]) begin
      fails++;
      $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, hist[3]);
    end
    if (out_valid === 1'b1) begin
      checks++;
      if (rptr == wptr) begin
        fails++;
        $display("FAIL R2 unexpected result actual=1 expected=0 pending");
      end else begin
        if (int'(z_sign) != q_s[rptr % 32] || int'(z_exp) != q_e[rptr % 32] ||
            int'(z_man) != q_m[rptr % 32]) begin
          fails++;
          $display("FAIL %s actual s=%0d e=%0d m=%0d expected s=%0d e=%0d m=%0d",
                   tag_name(q_t[rptr % 32]), z_sign, z_exp, z_man,
                   q_s[rptr % 32], q_e[rptr % 32], q_m[rptr % 32]);
        end
        rptr++;
      end
    end
  endtask

  task automatic step(input logic v, input int xs, xe, xm, ys, ye, ym, op);
    int rs, re, rm, rt;
    @(negedge clk);
    check_out();
    in_valid = v;
    x_sign = xs[0]; x_exp = EW'(xe); x_man = MW'(xm);
    y_sign = ys[0]; y_exp = EW'(ye); y_man = MW'(ym);
    op_sub = op[0];
    if (v) begin
      model(xs, xe, xm, ys, ye, ym, op, rs, re, rm, rt);
      q_s[wptr % 32] = rs; q_e[wptr % 32] = re;
      q_m[wptr % 32] = rm; q_t[wptr % 32] = rt;
      wptr++;
    end
    hist = {hist[2:0], v};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    report();
    $finish;
  end

  initial begin
    int ea [8];
    int eb [8];
    int n;
    ea = '{3, 5, 2, 9, 1, 15, 1, 15};
    eb = '{3, 4, 5, 1, 7, 15, 1, 12};
    n = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (out_valid !== 1'b0 || z_man !== '0 || z_exp !== '0 || z_sign !== 1'b0) begin
      fails++;
      $display("FAIL R10 actual v=%0b s=%0b e=%0d m=%0d expected all zero",
               out_valid, z_sign, z_exp, z_man);
    end
    rst = 1'b0;
    // R1..R9 sweep: all mantissa pairs, signs and operations per exponent pair
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 8; c++) begin
        for (int a = 0; a <= NM; a++) begin
          for (int b = 0; b <= NM; b++) begin
            step(1'b1, c & 1, ea[p], (a == NM) ? 0 : NM + a,
                 (c >> 1) & 1, eb[p], (b == NM) ? 0 : NM + b, (c >> 2) & 1);
            n++;
            if (n % 13 == 0) step(1'b0, 0, 0, 0, 0, 0, 0, 0);
          end
        end
      end
    end
    repeat (6) step(1'b0, 0, 0, 0, 0, 0, 0, 0);
    // R2: every issued operation produced exactly one result
    checks++;
    if (rptr != wptr) begin
      fails++;
      $display("FAIL R2 results actual=%0d expected=%0d", rptr, wptr);
    end
    report();
    $finish;
  end
endmodule